// File: doc/BRIEF.md
# Debug Data-Bus Scan Chain

This block wraps a 33-cell serial scan path around a processor core's 32-bit data bus and its breakpoint input. Each cell pairs one shift register with a selector that chooses between functional data and scanned data. Capture, shift and update strobes, a Run-Test/Idle indication and a mode code all come from an external test-access controller. This block only carries out those commands on the cells.

There are three modes. In pass-through mode the cells stay idle and functional data flows between core and system unchanged. In internal-test mode the scanned pattern drives the core's data input and breakpoint input. A capture then samples what the core drives out. In external-test mode, capture samples the data and breakpoint values arriving from the system. The scanned pattern goes to the system side of the data bus only when an update strobe occurs.

The cells have no update stage, so the scanned values that reach the core change on every shift clock. After the core enters debug, the first capture of the breakpoint cell returns the cause of entry instead of the live breakpoint input.

Top module: `dbg_bus_scan_chain`

## Requirements
- R1: After synchronous reset every cell, the external-test output holding register and the pending debug-cause flag are zero, so `scan_out` and `core_step` read 0.
- R2: With `mode` 2'b00 (pass-through) or 2'b11 (treated as pass-through), `core_din` equals `sys_din`, `sys_dout` equals `core_dout` and `core_brk` equals `sys_brk`. Capture and shift strobes leave the cell contents unchanged.
- R3: With `mode` 2'b01 or 2'b10, each clock with `shift` high and `capture` low moves the chain one place. `scan_in` enters at the breakpoint cell (index 32) and `scan_out` shows data cell 0. After 33 shifts, the first bit shifted in sits in cell 0.
- R4: With `mode` 2'b01 (internal test), a capture loads `core_dout` into cells 31..0 and `sys_brk` into cell 32, unless a debug cause is pending (see R8).
- R5: In internal test, `core_din` equals cells 31..0, `core_brk` equals cell 32 and `sys_dout` equals `core_dout`. The values on `core_din` and `core_brk` follow every shift immediately, with no update stage.
- R6: With `mode` 2'b10 (external test), a capture loads `sys_din` into cells 31..0 and `sys_brk` into cell 32, unless a debug cause is pending.
- R7: In external test, `sys_dout` shows a holding register. That register changes only on a clock with `update` high, when it loads cells 31..0. Meanwhile `core_din` equals `sys_din` and `core_brk` equals `sys_brk`.
- R8: A `dbg_entry` pulse records `entry_wp` as the debug cause: 0 for a breakpoint, 1 for a watchpoint. The next capture in internal or external test loads that cause into cell 32 and clears it. Pass-through captures do not consume it, and later captures sample `sys_brk`.
- R9: `core_step` is high for exactly one cycle: the first cycle of a stretch in which `rti` is high while in internal test. It stays low in the other modes.
- R10: When `capture` and `shift` are both high, the capture takes effect and the shift is dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Test clock |
| rst | input | 1 | Synchronous active-high reset |
| mode | input | 2 | 00 pass-through, 01 internal test, 10 external test, 11 pass-through |
| capture | input | 1 | Capture strobe for the data register |
| shift | input | 1 | Shift strobe for the data register |
| update | input | 1 | Update strobe for the data register |
| rti | input | 1 | Controller is in Run-Test/Idle |
| scan_in | input | 1 | Serial data in |
| scan_out | output | 1 | Serial data out (cell 0) |
| sys_din | input | 32 | Data arriving from the system |
| core_din | output | 32 | Data delivered to the core |
| core_dout | input | 32 | Data driven by the core |
| sys_dout | output | 32 | Data delivered to the system |
| sys_brk | input | 1 | Breakpoint request from the system |
| core_brk | output | 1 | Breakpoint request delivered to the core |
| dbg_entry | input | 1 | Pulse: core has just entered debug |
| entry_wp | input | 1 | Cause of debug entry: 1 watchpoint, 0 breakpoint |
| core_step | output | 1 | One-cycle core clock enable in internal test |

## Verification
A corrupted cell appears on `core_din` or `core_brk` in the same cycle during internal test. On `scan_out` it appears at the latest 33 shifts later, in the bit position matching the cell. A holding register that changes at the wrong time shows on `sys_dout` before any update strobe in external test. A stale or lost debug-cause flag shows up as a wrong top bit in the first scan-out after debug entry, or in the one after it. A broken edge detector on `rti` shows as a `core_step` that lasts longer than one cycle or that appears outside internal test.

// File: rtl/dbs_pkg.sv
package dbs_pkg;

  typedef enum logic [1:0] {
    DBS_SYSTEM = 2'b00,
    DBS_INTEST = 2'b01,
    DBS_EXTEST = 2'b10,
    DBS_RSVD   = 2'b11
  } dbs_mode_e;

  function automatic logic dbs_is_test(input dbs_mode_e m);
    return (m == DBS_INTEST) || (m == DBS_EXTEST);
  endfunction

endpackage

// File: rtl/dbs_cell.sv
module dbs_cell (
  input  logic clk,
  input  logic rst,
  input  logic cap_en,
  input  logic shift_en,
  input  logic cap_d,
  input  logic ser_in,
  output logic q
);

  always_ff @(posedge clk) begin
    if (rst) begin
      q <= 1'b0;
    end else if (cap_en) begin
      q <= cap_d;
    end else if (shift_en) begin
      q <= ser_in;
    end
  end

endmodule

// File: rtl/dbs_chain.sv
module dbs_chain #(
  parameter int W = 33
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         cap_en,
  input  logic         shift_en,
  input  logic [W-1:0] cap_vec,
  input  logic         tdi,
  output logic [W-1:0] vec,
  output logic         tdo
);

  localparam int TOP = W - 1;

  for (genvar g = 0; g < W; g++) begin : g_cell
    logic ser_src;
    if (g == TOP) begin : g_head
      assign ser_src = tdi;
    end else begin : g_link
      assign ser_src = vec[g+1];
    end
    dbs_cell u_cell (
      .clk      (clk),
      .rst      (rst),
      .cap_en   (cap_en),
      .shift_en (shift_en),
      .cap_d    (cap_vec[g]),
      .ser_in   (ser_src),
      .q        (vec[g])
    );
  end

  assign tdo = vec[0];

  // R3
  shift_move_chk: assert property (@(posedge clk) disable iff (rst)
    (shift_en && !cap_en) |=> (tdo == $past(vec[1])) && (vec[TOP] == $past(tdi)));

  // R10
  cap_win_chk: assert property (@(posedge clk) disable iff (rst)
    cap_en |=> (vec == $past(cap_vec)));

endmodule

// File: rtl/dbs_reason.sv
module dbs_reason (
  input  logic clk,
  input  logic rst,
  input  logic dbg_entry,
  input  logic entry_wp,
  input  logic cap_fire,
  output logic pending,
  output logic reason
);

  always_ff @(posedge clk) begin
    if (rst) begin
      pending <= 1'b0;
      reason  <= 1'b0;
    end else if (dbg_entry) begin
      pending <= 1'b1;
      reason  <= entry_wp;
    end else if (cap_fire) begin
      pending <= 1'b0;
    end
  end

  // R8
  reason_latch_chk: assert property (@(posedge clk) disable iff (rst)
    dbg_entry |=> pending && (reason == $past(entry_wp)));

  // R8
  reason_consumed_chk: assert property (@(posedge clk) disable iff (rst)
    (cap_fire && !dbg_entry) |=> !pending);

endmodule

// File: rtl/dbs_drive.sv
module dbs_drive import dbs_pkg::*; #(
  parameter int DW = 32
) (
  input  logic          clk,
  input  logic          rst,
  input  dbs_mode_e     mode,
  input  logic          update,
  input  logic          rti,
  input  logic [DW:0]   chain,
  input  logic [DW-1:0] sys_din,
  input  logic [DW-1:0] core_dout,
  input  logic          sys_brk,
  output logic [DW-1:0] core_din,
  output logic [DW-1:0] sys_dout,
  output logic          core_brk,
  output logic          core_step
);

  logic [DW-1:0] upd_q;
  logic          rti_seen;
  logic          upd_fire;

  assign upd_fire = update && (mode == DBS_EXTEST);

  always_ff @(posedge clk) begin
    if (rst) begin
      upd_q    <= '0;
      rti_seen <= 1'b0;
    end else begin
      rti_seen <= rti;
      if (upd_fire) begin
        upd_q <= chain[DW-1:0];
      end
    end
  end

  always_comb begin
    core_din = sys_din;
    sys_dout = core_dout;
    core_brk = sys_brk;
    unique case (mode)
      DBS_INTEST: begin
        core_din = chain[DW-1:0];
        core_brk = chain[DW];
      end
      DBS_EXTEST: begin
        sys_dout = upd_q;
      end
      default: ;
    endcase
  end

  assign core_step = rti && !rti_seen && (mode == DBS_INTEST);

  // R7
  upd_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !upd_fire |=> $stable(upd_q));

  // R9
  step_single_chk: assert property (@(posedge clk) disable iff (rst)
    core_step |=> !core_step);

endmodule

// File: rtl/dbg_bus_scan_chain.sv
module dbg_bus_scan_chain import dbs_pkg::*; #(
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [1:0]        mode,
  input  logic              capture,
  input  logic              shift,
  input  logic              update,
  input  logic              rti,
  input  logic              scan_in,
  output logic              scan_out,
  input  logic [DATA_W-1:0] sys_din,
  output logic [DATA_W-1:0] core_din,
  input  logic [DATA_W-1:0] core_dout,
  output logic [DATA_W-1:0] sys_dout,
  input  logic              sys_brk,
  output logic              core_brk,
  input  logic              dbg_entry,
  input  logic              entry_wp,
  output logic              core_step
);

  localparam int CHAIN_W = DATA_W + 1;
  localparam int BRK_POS = DATA_W;

  dbs_mode_e          mode_e;
  logic               active;
  logic               cap_fire;
  logic               shift_fire;
  logic               pending;
  logic               reason;
  logic [CHAIN_W-1:0] cap_vec;
  logic [CHAIN_W-1:0] chain_q;

  assign mode_e     = dbs_mode_e'(mode);
  assign active     = dbs_is_test(mode_e);
  assign cap_fire   = capture && active;
  assign shift_fire = shift && active && !capture;

  always_comb begin
    cap_vec[DATA_W-1:0] = (mode_e == DBS_INTEST) ? core_dout : sys_din;
    cap_vec[BRK_POS]    = pending ? reason : sys_brk;
  end

  dbs_reason u_reason (
    .clk       (clk),
    .rst       (rst),
    .dbg_entry (dbg_entry),
    .entry_wp  (entry_wp),
    .cap_fire  (cap_fire),
    .pending   (pending),
    .reason    (reason)
  );

  dbs_chain #(.W(CHAIN_W)) u_chain (
    .clk      (clk),
    .rst      (rst),
    .cap_en   (cap_fire),
    .shift_en (shift_fire),
    .cap_vec  (cap_vec),
    .tdi      (scan_in),
    .vec      (chain_q),
    .tdo      (scan_out)
  );

  dbs_drive #(.DW(DATA_W)) u_drive (
    .clk       (clk),
    .rst       (rst),
    .mode      (mode_e),
    .update    (update),
    .rti       (rti),
    .chain     (chain_q),
    .sys_din   (sys_din),
    .core_dout (core_dout),
    .sys_brk   (sys_brk),
    .core_din  (core_din),
    .sys_dout  (sys_dout),
    .core_brk  (core_brk),
    .core_step (core_step)
  );

  // R2
  sys_idle_chk: assert property (@(posedge clk) disable iff (rst)
    !active |=> $stable(chain_q));

endmodule

// File: tb/test_dbg_bus_scan_chain.sv
module test_dbg_bus_scan_chain;

  logic        clk = 1'b0;
  logic        rst;
  logic [1:0]  mode;
  logic        capture, shift, update, rti, scan_in;
  logic        scan_out;
  logic [31:0] sys_din, core_din, core_dout, sys_dout;
  logic        sys_brk, core_brk, dbg_entry, entry_wp, core_step;

  int checks = 0;
  int errors = 0;

  always #5 clk = ~clk;

  dbg_bus_scan_chain i_dbg_bus_scan_chain (
    .clk(clk), .rst(rst), .mode(mode), .capture(capture), .shift(shift),
    .update(update), .rti(rti), .scan_in(scan_in), .scan_out(scan_out),
    .sys_din(sys_din), .core_din(core_din), .core_dout(core_dout),
    .sys_dout(sys_dout), .sys_brk(sys_brk), .core_brk(core_brk),
    .dbg_entry(dbg_entry), .entry_wp(entry_wp), .core_step(core_step)
  );

  typedef struct packed {
    logic [1:0]  m;
    logic [31:0] sdin;
    logic [31:0] cdout;
    logic        sbrk;
    logic [31:0] e_cdin;
    logic [31:0] e_sdout;
    logic        e_brk;
  } vec_t;

  localparam int NV = 5;
  localparam vec_t VECS [NV] = '{
    vec_t'{2'b00, 32'h0000_FFFF, 32'h1357_9BDF, 1'b1, 32'h0000_FFFF, 32'h1357_9BDF, 1'b1},
    vec_t'{2'b11, 32'hCAFE_0001, 32'h8000_0000, 1'b0, 32'hCAFE_0001, 32'h8000_0000, 1'b0},
    vec_t'{2'b01, 32'h5555_AAAA, 32'h0F0F_0F0F, 1'b1, 32'h0000_0000, 32'h0F0F_0F0F, 1'b0},
    vec_t'{2'b10, 32'hFFFF_FFFF, 32'h2468_ACE0, 1'b1, 32'hFFFF_FFFF, 32'h0000_0000, 1'b1},
    vec_t'{2'b00, 32'h0000_0000, 32'hFFFF_FFFF, 1'b0, 32'h0000_0000, 32'hFFFF_FFFF, 1'b0}
  };

  task automatic chk(input string tag, input logic [32:0] act, input logic [32:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic cyc();
    @(posedge clk);
    #2;
  endtask

  task automatic scan33(input logic [32:0] din, output logic [32:0] dout);
    shift = 1'b1;
    for (int i = 0; i < 33; i++) begin
      scan_in = din[i];
      #1;
      dout[i] = scan_out;
      cyc();
    end
    shift = 1'b0;
    scan_in = 1'b0;
  endtask

  task automatic pulse_capture();
    capture = 1'b1;
    cyc();
    capture = 1'b0;
  endtask

  initial begin
    #200000;
    errors++;
    $display("FAIL watchdog actual hung expected done");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    logic [32:0] got;
    logic [32:0] p1, p2, q;
    rst = 1'b1; mode = 2'b00; capture = 1'b0; shift = 1'b0; update = 1'b0;
    rti = 1'b0; scan_in = 1'b0; sys_din = '0; core_dout = '0; sys_brk = 1'b0;
    dbg_entry = 1'b0; entry_wp = 1'b0;
    repeat (3) cyc();
    rst = 1'b0;
    cyc();

    // R1 reset state
    chk("R1 scan_out", {32'h0, scan_out}, 33'h0);
    chk("R1 core_step", {32'h0, core_step}, 33'h0);

    // R2 R5 R7 table of mode/data vectors right after reset
    for (int v = 0; v < NV; v++) begin
      mode = VECS[v].m; sys_din = VECS[v].sdin; core_dout = VECS[v].cdout;
      sys_brk = VECS[v].sbrk;
      #1;
      chk("R2/R5/R7 table core_din", {1'b0, core_din}, {1'b0, VECS[v].e_cdin});
      chk("R2/R5/R7 table sys_dout", {1'b0, sys_dout}, {1'b0, VECS[v].e_sdout});
      chk("R2/R5/R7 table core_brk", {32'h0, core_brk}, {32'h0, VECS[v].e_brk});
    end

    // R2 capture and shift ignored in pass-through
    mode = 2'b00; core_dout = 32'hDEAD_BEEF; sys_din = 32'h1234_5678; sys_brk = 1'b1;
    pulse_capture();
    shift = 1'b1; scan_in = 1'b1;
    repeat (5) cyc();
    shift = 1'b0; scan_in = 1'b0;
    chk("R2 idle scan_out", {32'h0, scan_out}, 33'h0);

    // R3 R5 load pattern in internal test, old contents come out zero
    mode = 2'b01;
    p1 = 33'h1_9ABC_DEF1;
    scan33(p1, got);
    chk("R2 R3 chain untouched by idle strobes", got, 33'h0);
    chk("R5 core_din after load", {1'b0, core_din}, {1'b0, p1[31:0]});
    chk("R5 core_brk after load", {32'h0, core_brk}, {32'h0, p1[32]});
    chk("R5 sys_dout passes core", {1'b0, sys_dout}, {1'b0, core_dout});

    // R5 one more shift changes core_din immediately
    shift = 1'b1; scan_in = 1'b0;
    cyc();
    shift = 1'b0;
    chk("R5 core_din follows shift", {1'b0, core_din}, {1'b0, p1[32:1]});
    chk("R5 core_brk follows shift", {32'h0, core_brk}, 33'h0);

    // R4 internal-test capture
    core_dout = 32'hA5C3_0F96; sys_brk = 1'b1;
    pulse_capture();
    p2 = 33'h0_0F0F_1234;
    scan33(p2, got);
    chk("R4 intest capture", got, {1'b1, 32'hA5C3_0F96});

    // R10 capture beats shift
    core_dout = 32'h7E57_C0DE; sys_brk = 1'b0;
    capture = 1'b1; shift = 1'b1; scan_in = 1'b1;
    cyc();
    capture = 1'b0; shift = 1'b0; scan_in = 1'b0;
    chk("R10 scan_out after joint strobe", {32'h0, scan_out}, {32'h0, 1'b0});
    scan33(33'h0, got);
    chk("R10 capture wins", got, {1'b0, 32'h7E57_C0DE});

    // R6 R7 external test
    mode = 2'b10; sys_din = 32'hC001_D00D; sys_brk = 1'b1; core_dout = 32'h1111_2222;
    #1;
    chk("R7 sys_dout before update", {1'b0, sys_dout}, 33'h0);
    pulse_capture();
    q = 33'h0_3C3C_5A5A;
    scan33(q, got);
    chk("R6 extest capture", got, {1'b1, 32'hC001_D00D});
    chk("R7 sys_dout held while shifting", {1'b0, sys_dout}, 33'h0);
    chk("R7 core_din from system", {1'b0, core_din}, {1'b0, 32'hC001_D00D});
    chk("R7 core_brk from system", {32'h0, core_brk}, 33'h1);
    update = 1'b1;
    cyc();
    update = 1'b0;
    chk("R7 sys_dout after update", {1'b0, sys_dout}, {1'b0, q[31:0]});
    shift = 1'b1; scan_in = 1'b1;
    repeat (4) cyc();
    shift = 1'b0; scan_in = 1'b0;
    chk("R7 sys_dout stable after update", {1'b0, sys_dout}, {1'b0, q[31:0]});

    // R8 debug cause: watchpoint, not consumed by pass-through capture
    mode = 2'b00; sys_brk = 1'b0;
    dbg_entry = 1'b1; entry_wp = 1'b1;
    cyc();
    dbg_entry = 1'b0; entry_wp = 1'b0;
    pulse_capture();
    mode = 2'b01;
    pulse_capture();
    scan33(33'h0, got);
    chk("R8 first capture watchpoint", {32'h0, got[32]}, 33'h1);
    pulse_capture();
    scan33(33'h0, got);
    chk("R8 later capture samples input", {32'h0, got[32]}, 33'h0);
    sys_brk = 1'b1;
    dbg_entry = 1'b1; entry_wp = 1'b0;
    cyc();
    dbg_entry = 1'b0;
    pulse_capture();
    scan33(33'h0, got);
    chk("R8 first capture breakpoint", {32'h0, got[32]}, 33'h0);
    pulse_capture();
    scan33(33'h0, got);
    chk("R8 next capture samples input", {32'h0, got[32]}, 33'h1);

    // R9 single core step in internal test
    mode = 2'b01; rti = 1'b1;
    #1;
    chk("R9 step on first idle cycle", {32'h0, core_step}, 33'h1);
    cyc();
    chk("R9 step drops", {32'h0, core_step}, 33'h0);
    cyc();
    chk("R9 step stays low", {32'h0, core_step}, 33'h0);
    rti = 1'b0;
    cyc();
    mode = 2'b10; rti = 1'b1;
    #1;
    chk("R9 no step in external test", {32'h0, core_step}, 33'h0);
    cyc();
    rti = 1'b0;

    // R1 reset again clears everything
    rst = 1'b1;
    cyc();
    rst = 1'b0;
    mode = 2'b01;
    #1;
    chk("R1 core_din after reset", {1'b0, core_din}, 33'h0);
    mode = 2'b10;
    #1;
    chk("R1 holding register after reset", {1'b0, sys_dout}, 33'h0);

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule